// File: doc/BRIEF.md
# Write-Protected Programmable Bus Address

This block keeps the live 7-bit slave address of a device on a two-wire serial bus in a volatile shadow register, and compares it every cycle with the address byte the bus engine has just received. The address can be changed from the host register port, but only in two steps. First the host sets a write-enable bit in a feature register. Then it writes the new address to the address location. The new value is used for matching from the next cycle on, so the next bus transaction must use it.

The shadow value is volatile. At power-up it is loaded from the nonvolatile copy. A block-copy strobe emits the current shadow value on a save port, and the external store keeps it from then on. If power is lost before a copy, the old stored address comes back. The feature register also holds a pin sense and control bit. A read of that bit returns the pin level. Writing 0 to it drives the pin low. Power-up and sleep release the pin.

Top module: `prog_bus_addr`

## Requirements
- R1: While `rstN` is low, the shadow address loads from `nvLoadAddr`. After reset, the write-enable bit (feature register 15h, bit 1) is 0, the pin control bit (bit 0) is 1, and `pioDriveLow` is 0.
- R2: A write to 15h while `sleep` is low loads bit 1 into the write-enable bit and bit 0 into the pin control bit. A read of 15h returns the write-enable bit in bit 1, the `pioSense` level in bit 0, and zeros in bits 7:2.
- R3: A write to 7Eh while the write-enable bit is 1 loads data bits 7:1 into the shadow address at the next clock edge. A read of 7Eh returns the shadow address in bits 7:1 and 0 in bit 0.
- R4: A write to 7Eh while the write-enable bit is 0 leaves the shadow address unchanged.
- R5: `addrHit` is 1 in the same cycle exactly when `busAddrByte[7:1]` equals the shadow address. Bit 0 of the byte is ignored. A new address matches in the cycle after its write.
- R6: In the cycle in which `copyBlk` is high, `nvSave` is high and `nvSaveData` carries the shadow address.
- R7: A reset with no copy since the last change restores the address last saved. The factory stored value is 0110100b.
- R8: While the pin control bit is 0, `pioDriveLow` is 1. A cycle with `sleep` high sets the control bit back to 1 and leaves the write-enable bit alone. A write to 15h in a sleep cycle is dropped.
- R9: Writes to any address other than 15h and 7Eh change nothing. Reads of any other address return 0.
- R10: When a copy and an accepted address write happen in the same cycle, `nvSaveData` carries the address from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-up reset, synchronous |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 8 | Register read address |
| rdData | output | 8 | Register read data (combinational) |
| busAddrByte | input | 8 | Address byte received from the bus |
| addrHit | output | 1 | Received address equals the live address |
| copyBlk | input | 1 | Copy-to-nonvolatile strobe for the parameter block |
| nvSave | output | 1 | Save pulse to the nonvolatile store |
| nvSaveData | output | 7 | Address value to save |
| nvLoadAddr | input | 7 | Stored address presented at power-up |
| sleep | input | 1 | Device is in sleep |
| pioSense | input | 1 | Sensed pin level |
| pioDriveLow | output | 1 | Pin open-drain driver enable |

## Verification
The bench builds the block with its default parameters: an 8-bit register address and data path, a 7-bit slave address field, and the enable and pin bits at positions 1 and 0. With these values every one of the 128 addresses can be written and read back. For a spread of these addresses, the match is checked against all 256 received bytes. This covers the ignored bit 0 and every near-miss neighbour. A bench model of the nonvolatile store makes power-cycle restore and the copy-during-write ordering observable at the ports.

// File: rtl/prog_bus_addr_pkg.sv
package prog_bus_addr_pkg;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_FEAT = 2'd1,
    RD_SLV  = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic loadShadow;
    logic loadFeat;
    logic releasePin;
    logic saveNv;
  } ctrlStrb_t;

endpackage

// File: rtl/prog_bus_addr_ctrl.sv
module prog_bus_addr_ctrl
  import prog_bus_addr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] FEAT_ADDR = 8'h15,
  parameter logic [ADDR_W-1:0] SLV_ADDR = 8'h7E
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              copyBlk,
  input  logic              sleep,
  input  logic              weQ,
  output ctrlStrb_t         strb,
  output rdSel_e            rdSel
);

  logic hitFeatWr;
  logic hitSlvWr;

  assign hitFeatWr = wrEn && (wrAddr == FEAT_ADDR);
  assign hitSlvWr  = wrEn && (wrAddr == SLV_ADDR);

  always_comb begin
    strb.loadShadow = hitSlvWr && weQ;
    strb.loadFeat   = hitFeatWr && !sleep;
    strb.releasePin = sleep;
    strb.saveNv     = copyBlk;
  end

  always_comb begin
    if (rdAddr == FEAT_ADDR)     rdSel = RD_FEAT;
    else if (rdAddr == SLV_ADDR) rdSel = RD_SLV;
    else                         rdSel = RD_NONE;
  end

endmodule

// File: rtl/prog_bus_addr_dp.sv
module prog_bus_addr_dp
  import prog_bus_addr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SLV_W = 7,
  parameter int WE_BIT = 1,
  parameter int PIN_BIT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  rdSel_e            rdSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SLV_W-1:0]  nvLoadAddr,
  input  logic [DATA_W-1:0] busAddrByte,
  input  logic              pioSense,
  output logic [DATA_W-1:0] rdData,
  output logic              addrHit,
  output logic              nvSave,
  output logic [SLV_W-1:0]  nvSaveData,
  output logic              pioDriveLow,
  output logic              weQ
);

  localparam int RSV_W = DATA_W - SLV_W;

  logic [SLV_W-1:0] shadowQ;
  logic             pinCtlQ;
  logic [SLV_W-1:0] bitEq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowQ <= nvLoadAddr;
    end else if (strb.loadShadow) begin
      shadowQ <= wrData[DATA_W-1:RSV_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weQ     <= 1'b0;
      pinCtlQ <= 1'b1;
    end else if (strb.releasePin) begin
      pinCtlQ <= 1'b1;
    end else if (strb.loadFeat) begin
      weQ     <= wrData[WE_BIT];
      pinCtlQ <= wrData[PIN_BIT];
    end
  end

  for (genvar i = 0; i < SLV_W; i++) begin : g_cmp
    assign bitEq[i] = ~(busAddrByte[RSV_W+i] ^ shadowQ[i]);
  end

  assign addrHit     = &bitEq;
  assign pioDriveLow = ~pinCtlQ;
  assign nvSave      = strb.saveNv;
  assign nvSaveData  = shadowQ;

  always_comb begin
    rdData = '0;
    case (rdSel)
      RD_FEAT: begin
        rdData[WE_BIT]  = weQ;
        rdData[PIN_BIT] = pioSense;
      end
      RD_SLV:  rdData = {shadowQ, {RSV_W{1'b0}}};
      default: rdData = '0;
    endcase
  end

  // R3: an accepted address write shows up in the comparator one cycle later
  a_r3_hit_after_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadShadow |=> (bitEq == {SLV_W{1'b1}}) == (busAddrByte[DATA_W-1:RSV_W] == $past(wrData[DATA_W-1:RSV_W])));

  // R8: sleep releases the pin on the following cycle
  a_r8_sleep_release: assert property (@(posedge clk) disable iff (!rstN)
    strb.releasePin |=> !pioDriveLow);

endmodule

// File: rtl/prog_bus_addr.sv
module prog_bus_addr
  import prog_bus_addr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SLV_W = 7,
  parameter int WE_BIT = 1,
  parameter int PIN_BIT = 0,
  parameter logic [ADDR_W-1:0] FEAT_ADDR = 8'h15,
  parameter logic [ADDR_W-1:0] SLV_ADDR = 8'h7E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] busAddrByte,
  output logic              addrHit,
  input  logic              copyBlk,
  output logic              nvSave,
  output logic [SLV_W-1:0]  nvSaveData,
  input  logic [SLV_W-1:0]  nvLoadAddr,
  input  logic              sleep,
  input  logic              pioSense,
  output logic              pioDriveLow
);

  ctrlStrb_t strb;
  rdSel_e    rdSel;
  logic      weQ;

  prog_bus_addr_ctrl #(
    .ADDR_W(ADDR_W), .FEAT_ADDR(FEAT_ADDR), .SLV_ADDR(SLV_ADDR)
  ) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .rdAddr(rdAddr), .copyBlk(copyBlk),
    .sleep(sleep), .weQ(weQ), .strb(strb), .rdSel(rdSel)
  );

  prog_bus_addr_dp #(
    .DATA_W(DATA_W), .SLV_W(SLV_W), .WE_BIT(WE_BIT), .PIN_BIT(PIN_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(rdSel), .wrData(wrData),
    .nvLoadAddr(nvLoadAddr), .busAddrByte(busAddrByte), .pioSense(pioSense),
    .rdData(rdData), .addrHit(addrHit), .nvSave(nvSave),
    .nvSaveData(nvSaveData), .pioDriveLow(pioDriveLow), .weQ(weQ)
  );

  // R4: with the enable clear, an address write leaves the saved value stable
  a_r4_locked_hold: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == SLV_ADDR && !weQ) |=> $stable(nvSaveData));

  // R3: with the enable set, the written field becomes the live address
  a_r3_unlocked_load: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == SLV_ADDR && weQ) |=> nvSaveData == $past(wrData[DATA_W-1:DATA_W-SLV_W]));

  // R2: a feature write outside sleep lands in the enable bit
  a_r2_enable_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == FEAT_ADDR && !sleep) |=> weQ == $past(wrData[WE_BIT]));

  // R9: writes elsewhere leave the live address alone
  a_r9_other_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr != SLV_ADDR) |=> $stable(nvSaveData));

endmodule

// File: tb/prog_bus_addr_test.sv
module prog_bus_addr_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic       wrEn;
  logic [7:0] wrAddr, wrData, rdAddr, rdData, busAddrByte;
  logic       addrHit, copyBlk, nvSave, sleep, pioSense, pioDriveLow;
  logic [6:0] nvSaveData;
  logic [6:0] nvMem = 7'b0110100;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  always @(posedge clk) if (nvSave) nvMem <= nvSaveData;

  prog_bus_addr uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .busAddrByte(busAddrByte),
    .addrHit(addrHit), .copyBlk(copyBlk), .nvSave(nvSave),
    .nvSaveData(nvSaveData), .nvLoadAddr(nvMem), .sleep(sleep),
    .pioSense(pioSense), .pioDriveLow(pioDriveLow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string req, input logic [7:0] exp);
    rdAddr = a; #1;
    chk(req, rdData, exp);
  endtask

  task automatic hit(input logic [7:0] b, input string req, input logic exp);
    busAddrByte = b; #1;
    chk(req, addrHit, exp);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; wrEn = 0; wrAddr = 0; wrData = 0; rdAddr = 0;
    busAddrByte = 0; copyBlk = 0; sleep = 0; pioSense = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h15, "R1 feature after reset", 8'h01);
    chk("R1 pin released", pioDriveLow, 1'b0);
    rd(8'h7E, "R1 factory address", 8'h68);
    hit(8'h68, "R5 factory match", 1'b1);
    hit(8'h69, "R5 bit0 ignored", 1'b1);

    // R4 write with enable clear
    wr(8'h7E, 8'hAA);
    rd(8'h7E, "R4 locked write ignored", 8'h68);
    hit(8'hAA, "R4 no match on rejected", 1'b0);

    // R2 feature register
    wr(8'h15, 8'h03);
    rd(8'h15, "R2 enable set", 8'h03);
    pioSense = 1'b0;
    rd(8'h15, "R2 sense low", 8'h02);
    pioSense = 1'b1;
    chk("R2 pin released when bit0 1", pioDriveLow, 1'b0);

    // R8 pin drive and sleep
    wr(8'h15, 8'h02);
    chk("R8 drive low", pioDriveLow, 1'b1);
    @(negedge clk); sleep = 1'b1;
    @(negedge clk); sleep = 1'b0;
    chk("R8 sleep releases", pioDriveLow, 1'b0);
    rd(8'h15, "R8 enable kept", 8'h03);
    sleep = 1'b1;
    wr(8'h15, 8'h00);
    sleep = 1'b0;
    rd(8'h15, "R8 sleep write dropped", 8'h03);

    // R3 and R5 sweep over all addresses
    for (int a = 0; a < 128; a++) begin
      wr(8'h7E, {a[6:0], a[0]});
      rd(8'h7E, "R3 readback", {a[6:0], 1'b0});
      hit({a[6:0], 1'b0}, "R5 match bit0=0", 1'b1);
      hit({a[6:0], 1'b1}, "R5 match bit0=1", 1'b1);
      hit({a[6:0] + 7'd1, 1'b0}, "R5 neighbour miss", 1'b0);
      if (a % 21 == 0) begin
        for (int b = 0; b < 256; b++)
          hit(b[7:0], "R5 exhaustive", (b[7:1] == a[6:0]));
      end
    end

    // R9 other addresses
    wr(8'h16, 8'h10);
    wr(8'h7F, 8'h10);
    wr(8'h7D, 8'h10);
    rd(8'h7E, "R9 other writes ignored", 8'hFE);
    rd(8'h16, "R9 other read zero", 8'h00);
    rd(8'h00, "R9 other read zero", 8'h00);
    rd(8'h15, "R9 feature unchanged", 8'h03);

    // R7 reset without copy restores factory value
    doReset();
    rd(8'h7E, "R7 restore stored", 8'h68);
    rd(8'h15, "R1 enable cleared", 8'h01);

    // R6 and R10 copy with simultaneous write
    wr(8'h15, 8'h03);
    wr(8'h7E, 8'hAA);
    @(negedge clk);
    copyBlk = 1'b1; wrEn = 1'b1; wrAddr = 8'h7E; wrData = 8'h22;
    #1;
    chk("R6 save pulse", nvSave, 1'b1);
    chk("R10 save holds pre-write", nvSaveData, 7'h55);
    @(negedge clk);
    copyBlk = 1'b0; wrEn = 1'b0;
    #1;
    chk("R6 save pulse ends", nvSave, 1'b0);
    rd(8'h7E, "R10 write still taken", 8'h22);
    doReset();
    rd(8'h7E, "R7 restore copied", 8'hAA);
    hit(8'hAB, "R7 match copied", 1'b1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule